// File: doc/BRIEF.md
# Host Mailbox Register Block with Command and Completion Queues

This block is the device-side register file that a storage controller exposes to its host over a 32-bit memory-mapped port. The host hands over a command by writing the command's 32-bit bus address to a request port. Each write goes into a request queue, and the internal command engine drains that queue. When the engine finishes a command, it pushes a completion tag into a reply queue. The host collects the tag by reading the reply port. A read of the reply port while the reply queue holds nothing returns all ones, so the host can tell an empty read from a real tag.

The block also holds four registers. A doorbell register is readable and writable by the host and is driven out to the device. An interrupt status register reports a pending reply and a sticky request-overflow flag. An interrupt mask register works in inverted sense: setting bit 3 disables the reply interrupt, and clearing it enables the interrupt. A scratchpad register tells the host when the firmware is ready. The interrupt line is high while a reply is waiting and the mask does not block it.

Host reads pass through a two-state response machine. In state RSP_IDLE no data is presented. A read request moves the machine to RSP_DATA (transition IDLE_TO_DATA), where the captured word is held for one cycle with a valid flag. Another read in RSP_DATA keeps the machine there (DATA_TO_DATA). Otherwise the machine returns to RSP_IDLE (DATA_TO_IDLE).

Top module: `mbx_host_regs`

## Requirements
- R1: After reset, irq, host_rvalid, req_valid, req_full and rep_full are all 0. The mask register reads 0x00000008 (interrupt disabled), and the status register reads 0.
- R2: A host write to offset 0x40 appends host_wdata to the request queue. The device sees the oldest entry on req_data while req_valid is 1, and a req_pop pulse advances to the next entry in write order.
- R3: While the request queue holds DEPTH entries, req_full is 1. A write to 0x40 in that state is dropped and sets status bit 0. A host read of status (0x30) returns that bit as 1 and clears it, so the next status read returns 0.
- R4: A host read of offset 0x44 returns the oldest reply entry and removes it. If the reply queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R5: Status bit 3 (0x08) reads 1 exactly while the reply queue is non-empty, whatever the mask value.
- R6: irq is 1 exactly when the reply queue is non-empty and bit 3 of the mask register is 0. The mask register (0x34) reads back the last value written. irq follows a mask write from the next cycle.
- R7: The scratchpad (0xB0) reads 0 after reset. It reads 0xFFFF0000 from the cycle after dev_ready is sampled high and keeps that value afterwards. Host writes to the scratchpad have no effect.
- R8: The doorbell (0x20) reads back the last value the host wrote, and the same value is driven on db_out.
- R9: Read data appears on host_rdata with host_rvalid = 1 in the cycle after the read request. Offsets that are not mapped, including the request port, read as 0.
- R10: While the reply queue holds DEPTH entries, rep_full is 1 and a rep_push is dropped. The entries already stored are then read back in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 8 | Byte offset of the register accessed |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| req_pop | input | 1 | Device takes the request at the head of the queue |
| req_data | output | 32 | Oldest command address in the request queue |
| req_valid | output | 1 | Request queue non-empty |
| req_full | output | 1 | Request queue full |
| rep_push | input | 1 | Device pushes a completion tag |
| rep_data | input | 32 | Completion tag to push |
| rep_full | output | 1 | Reply queue full |
| dev_ready | input | 1 | Firmware ready indication |
| db_out | output | 32 | Current doorbell value |
| irq | output | 1 | Reply interrupt |

## Verification
The properties assume that the host raises at most one of host_wr and host_rd in a cycle, with a stable offset for that cycle. They also assume that the device pops the request queue only when req_valid is 1. The bench drives every host access as a single-cycle strobe from tasks. It issues req_pop only after it has confirmed req_valid, and it never overlaps a host access with another. Reply pushes are made while no host read of the reply port is in flight, so the order of tags in the queue is fully determined by the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_DOORBELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_MASK     = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_REQUEST  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_REPLY    = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_SCRATCH  = 8'hB0;

    localparam logic [DATA_W-1:0] EMPTY_WORD   = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] READY_WORD   = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] MASK_RESET   = 32'h0000_0008;

    localparam int MASK_BIT    = 3;
    localparam int PEND_BIT    = 3;
    localparam int OVF_BIT     = 0;

    typedef enum logic [0:0] {
        RSP_IDLE = 1'b0,
        RSP_DATA = 1'b1
    } rsp_state_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8   // power of two
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == DEPTH_C);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head_data = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/mbx_rd_fsm.sv
module mbx_rd_fsm
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    rsp_state_t        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: if (rd_req) state_d = RSP_DATA;          // IDLE_TO_DATA
            RSP_DATA: state_d = rd_req ? RSP_DATA : RSP_IDLE;  // DATA_TO_DATA / DATA_TO_IDLE
            default:  state_d = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // Output register: capture the word in the request cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (rd_req) data_q <= rd_word;
    end

    assign rvalid = (state_q == RSP_DATA);
    assign rdata  = rvalid ? data_q : '0;
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
    import mbx_pkg::*;
#(
    parameter int REQ_DEPTH = 8,
    parameter int REP_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              req_pop,
    output logic [DATA_W-1:0] req_data,
    output logic              req_valid,
    output logic              req_full,
    input  logic              rep_push,
    input  logic [DATA_W-1:0] rep_data,
    output logic              rep_full,
    input  logic              dev_ready,
    output logic [DATA_W-1:0] db_out,
    output logic              irq
);
    logic [DATA_W-1:0] db_q, mask_q, scratch_q, rd_word, rep_head, status_w;
    logic              ovf_q, req_empty, rep_empty, rep_pend;
    logic              req_push, ovf_evt, rep_pop, status_rd;

    assign req_push  = host_wr && (host_addr == OFF_REQUEST);
    assign ovf_evt   = req_push && req_full;
    assign rep_pop   = host_rd && (host_addr == OFF_REPLY) && !rep_empty;
    assign status_rd = host_rd && (host_addr == OFF_STATUS);
    assign rep_pend  = !rep_empty;

    mbx_fifo #(.DW(DATA_W), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_push),
        .push_data (host_wdata),
        .pop       (req_pop),
        .head_data (req_data),
        .empty     (req_empty),
        .full      (req_full)
    );

    mbx_fifo #(.DW(DATA_W), .DEPTH(REP_DEPTH)) u_rep_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rep_push),
        .push_data (rep_data),
        .pop       (rep_pop),
        .head_data (rep_head),
        .empty     (rep_empty),
        .full      (rep_full)
    );

    assign req_valid = !req_empty;

    // Host-writable registers, overflow flag and scratchpad
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q      <= '0;
            mask_q    <= MASK_RESET;
            scratch_q <= '0;
            ovf_q     <= 1'b0;
        end else begin
            if (host_wr && host_addr == OFF_DOORBELL) db_q   <= host_wdata;
            if (host_wr && host_addr == OFF_MASK)     mask_q <= host_wdata;
            if (dev_ready)                             scratch_q <= READY_WORD;
            if (ovf_evt)        ovf_q <= 1'b1;
            else if (status_rd) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        status_w           = '0;
        status_w[PEND_BIT] = rep_pend;
        status_w[OVF_BIT]  = ovf_q;
    end

    // Read decode
    always_comb begin
        unique case (host_addr)
            OFF_DOORBELL: rd_word = db_q;
            OFF_STATUS:   rd_word = status_w;
            OFF_MASK:     rd_word = mask_q;
            OFF_REPLY:    rd_word = rep_empty ? EMPTY_WORD : rep_head;
            OFF_SCRATCH:  rd_word = scratch_q;
            default:      rd_word = '0;
        endcase
    end

    mbx_rd_fsm u_rd_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (host_rd),
        .rd_word (rd_word),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    assign db_out = db_q;
    assign irq    = rep_pend && !mask_q[MASK_BIT];
endmodule

// File: rtl/mbx_host_regs_chk.sv
module mbx_host_regs_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rvalid,
    input logic              req_pop,
    input logic              req_valid,
    input logic              req_full,
    input logic              dev_ready,
    input logic              irq,
    input logic              rep_empty,
    input logic              ovf_q,
    input logic [DATA_W-1:0] scratch_q
);
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid); // R9

    AST_EMPTY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == OFF_REPLY && rep_empty |=> host_rdata == EMPTY_WORD); // R4

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == OFF_MASK && host_wdata[MASK_BIT] |=> !irq); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == OFF_REQUEST && req_full && !req_pop |=> ovf_q && req_full); // R3

    AST_SCRATCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |=> scratch_q == READY_WORD); // R7

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        req_full |-> req_valid); // R2
endmodule

bind mbx_host_regs mbx_host_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .req_pop     (req_pop),
    .req_valid   (req_valid),
    .req_full    (req_full),
    .dev_ready   (dev_ready),
    .irq         (irq),
    .rep_empty   (rep_empty),
    .ovf_q       (ovf_q),
    .scratch_q   (scratch_q)
);

// File: tb/mbx_host_regs_tb.sv
module mbx_host_regs_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        req_pop = 1'b0;
    logic [31:0] req_data;
    logic        req_valid, req_full;
    logic        rep_push = 1'b0;
    logic [31:0] rep_data = '0;
    logic        rep_full;
    logic        dev_ready = 1'b0;
    logic [31:0] db_out;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    mbx_host_regs #(.REQ_DEPTH(DEPTH), .REP_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .req_pop(req_pop), .req_data(req_data), .req_valid(req_valid), .req_full(req_full),
        .rep_push(rep_push), .rep_data(rep_data), .rep_full(rep_full),
        .dev_ready(dev_ready), .db_out(db_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    task automatic dev_push(input logic [31:0] d);
        @(negedge clk);
        rep_push = 1'b1; rep_data = d;
        @(negedge clk);
        rep_push = 1'b0;
    endtask

    task automatic dev_pop();
        @(negedge clk);
        req_pop = 1'b1;
        @(negedge clk);
        req_pop = 1'b0;
    endtask

    // {tag[3:0], is_write, addr[7:0], wdata[31:0], expected[31:0]}
    localparam int NV = 11;
    localparam logic [76:0] VEC [NV] = '{
        {4'd6, 1'b0, 8'h34, 32'h0,          32'h0000_0008},
        {4'd6, 1'b1, 8'h34, 32'h0,          32'h0},
        {4'd6, 1'b0, 8'h34, 32'h0,          32'h0},
        {4'd8, 1'b1, 8'h20, 32'hA5A5_0001,  32'h0},
        {4'd8, 1'b0, 8'h20, 32'h0,          32'hA5A5_0001},
        {4'd4, 1'b0, 8'h44, 32'h0,          32'hFFFF_FFFF},
        {4'd9, 1'b0, 8'h10, 32'h0,          32'h0},
        {4'd7, 1'b0, 8'hB0, 32'h0,          32'h0},
        {4'd7, 1'b1, 8'hB0, 32'h0000_1234,  32'h0},
        {4'd7, 1'b0, 8'hB0, 32'h0,          32'h0},
        {4'd1, 1'b0, 8'h30, 32'h0,          32'h0}
    };

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rvalid", {31'b0, host_rvalid}, 32'h0);
        check("R1 req_valid", {31'b0, req_valid}, 32'h0);
        check("R1 fulls", {30'b0, req_full, rep_full}, 32'h0);

        // Table-driven register accesses (R6 R7 R8 R9 R4 R1)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][71:64], d, v);
                check($sformatf("R%0d vec%0d", VEC[i][76:73], i), d, VEC[i][31:0]);
                check("R9 rvalid", {31'b0, v}, 32'h1);
            end
        end
        check("R8 db_out", db_out, 32'hA5A5_0001);
        rd(8'h40, d, v);
        check("R9 request port reads 0", d, 32'h0);

        // R2 request ordering
        wr(8'h40, 32'h1000_0000);
        wr(8'h40, 32'h1000_0040);
        check("R2 valid", {31'b0, req_valid}, 32'h1);
        check("R2 head first", req_data, 32'h1000_0000);
        dev_pop();
        check("R2 head second", req_data, 32'h1000_0040);
        dev_pop();
        check("R2 drained", {31'b0, req_valid}, 32'h0);

        // R3 overflow
        for (int i = 0; i < DEPTH; i++) wr(8'h40, 32'h2000_0000 + i);
        check("R3 full", {31'b0, req_full}, 32'h1);
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h30, d, v);
        check("R3 ovf set", d & 32'h1, 32'h1);
        rd(8'h30, d, v);
        check("R3 ovf cleared", d & 32'h1, 32'h0);
        for (int i = 0; i < DEPTH; i++) begin
            check("R3 kept entry", req_data, 32'h2000_0000 + i);
            dev_pop();
        end
        check("R3 extra dropped", {31'b0, req_valid}, 32'h0);

        // R5 R6 replies with interrupt (mask currently 0)
        dev_push(32'h0000_00A1);
        check("R6 irq on", {31'b0, irq}, 32'h1);
        dev_push(32'h0000_00A2);
        rd(8'h30, d, v);
        check("R5 pending", d & 32'h8, 32'h8);
        wr(8'h34, 32'h8);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        rd(8'h30, d, v);
        check("R5 pending while masked", d & 32'h8, 32'h8);
        rd(8'h44, d, v);
        check("R4 first tag", d, 32'h0000_00A1);
        wr(8'h34, 32'h0);
        check("R6 irq unmasked", {31'b0, irq}, 32'h1);
        rd(8'h44, d, v);
        check("R4 second tag", d, 32'h0000_00A2);
        check("R6 irq off when empty", {31'b0, irq}, 32'h0);
        rd(8'h44, d, v);
        check("R4 empty read", d, 32'hFFFF_FFFF);
        rd(8'h30, d, v);
        check("R5 not pending", d & 32'h8, 32'h0);

        // R10 reply full
        for (int i = 0; i <= DEPTH; i++) dev_push(32'h3000_0000 + i);
        check("R10 rep_full", {31'b0, rep_full}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h44, d, v);
            check("R10 order", d, 32'h3000_0000 + i);
        end
        rd(8'h44, d, v);
        check("R10 extra dropped", d, 32'hFFFF_FFFF);

        // R7 scratchpad ready
        @(negedge clk); dev_ready = 1'b1;
        @(negedge clk); dev_ready = 1'b0;
        rd(8'hB0, d, v);
        check("R7 ready", d, 32'hFFFF_0000);
        wr(8'hB0, 32'h0);
        rd(8'hB0, d, v);
        check("R7 sticky", d, 32'hFFFF_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule